// File: doc/BRIEF.md
# Legacy-to-Wide Register Translator

This block sits on the chipset register bus between two write paths. The first is the old 16-bit register path. The second is a 32-bit path that writes the new, wider register images directly. Every 16-bit write that lands on a translated legacy register is converted in a way that depends on the register, and the result is stored in the matching 32-bit image. The two kinds of write therefore always leave one consistent register file.

The translated registers are:

- the legacy colour registers, which are widened into two 256-entry true-colour palettes;
- the four blitter modulo registers;
- the length, period and volume registers of audio channels 0 to 3;
- the audio bits of the legacy set/clear registers for DMA enable, interrupt enable and interrupt request.

Each of these has its own per-channel 32-bit mask for all audio channels. A combinational read port returns any 32-bit image by its wide byte address. The three audio masks are also driven directly as outputs.

Top module: `compat_xlat`

## Requirements
- R1: A legacy write to colour register k (byte address 0x180 + 2k, k in 0..31) stores the 12-bit RGB in data[11:0] as 0x00RRGGBB. Each 4-bit nibble is doubled, so 0x0FA5 becomes 0x00FFAA55.
- R2: The expanded colour of R1 is written to entry k of both palettes. Palette A is read at wide address 0x800 + 4k and palette B at 0xC00 + 4k. No other palette entry changes.
- R3: A legacy write to modulo register i (address 0x060 + 2i, i in 0..3) stores the data sign-extended to 32 bits in the image at wide address 0x240 + 4i. For example, 0xFFFE becomes 0xFFFFFFFE.
- R4: A legacy write to the length register of channel c (0x0A4 + 16c, c in 0..3) stores twice the data, zero-extended, in the sample count at wide address 0x604 + 16c.
- R5: A legacy write to the period register of channel c (0x0A6 + 16c) places the data in bits 31..16 of the period/control image at 0x608 + 16c and clears bits 15..0.
- R6: A legacy write to the volume register of channel c (0x0A8 + 16c) first converts the level. Data bit 6 set gives 255; otherwise the level is data[5:0] * 4. For channels 0 and 3 the level goes to bits 7..0 and bits 15..8 are cleared. For channels 1 and 2 the level goes to bits 15..8 and bits 7..0 are cleared. Bits 31..16 are always cleared. The image is at 0x60C + 16c.
- R7: A legacy write to the DMA control register (0x096) with data bit 15 set sets the bits of the audio DMA mask (wide 0x280) selected by data[3:0]. With data bit 15 clear, it clears those bits. Channel c maps to mask bit c, and all other mask bits keep their value.
- R8: Legacy writes to the interrupt enable register (0x09A) and the interrupt request register (0x09C) act on the audio interrupt enable mask (0x284) and the audio interrupt request mask (0x288) in the same way as R7. Channel c is selected by data bit 7 + c.
- R9: A wide write with address bits 1..0 equal to zero stores all 32 data bits in the addressed image. A wide write with either of those bits set has no effect.
- R10: A wide write to any address below 0x200 has no effect, so side-effect registers can only be reached by 16-bit writes. Reads below 0x200 return zero.
- R11: When a legacy write and a wide write target the same image in the same cycle, the translated legacy value is the one stored.
- R12: After reset, every image reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| leg_we | input | 1 | Legacy 16-bit write strobe |
| leg_addr | input | 9 | Legacy register byte address |
| leg_data | input | 16 | Legacy write data |
| w_we | input | 1 | Wide write strobe |
| w_addr | input | 12 | Wide register byte address |
| w_data | input | 32 | Wide write data |
| rd_addr | input | 12 | Wide read byte address |
| rd_data | output | 32 | Image at rd_addr (combinational) |
| aud_dma_en | output | 32 | Per-channel audio DMA enable mask |
| aud_int_en | output | 32 | Per-channel audio interrupt enable mask |
| aud_int_req | output | 32 | Per-channel audio interrupt request mask |

## Verification
The bench aims at the following corners, each with the fault it would expose:

- Colour 0x0FA5, together with full-scale and zero nibbles. A wrong nibble order or a single-palette write shows up as a mismatched entry in one palette.
- Modulo values with bit 15 set and clear. Zero-extension shows up there.
- Volume level 64, volume levels with the maximum flag set, and every legacy channel. These expose a wrong byte routing, or rear bytes that survive the write.
- Set and clear writes to the masks on top of upper bits preloaded through the wide port. Bits lost outside the legacy channels show up there.
- Misaligned wide writes, wide writes into the 16-bit region, and same-cycle collisions. A design that lets the wide value win stores the raw word.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int LEG_CH = 4;

  // legacy byte addresses
  localparam logic [8:0] LA_AUD = 9'h0A0;
  localparam logic [8:0] LA_DMA = 9'h096;
  localparam logic [8:0] LA_IEN = 9'h09A;
  localparam logic [8:0] LA_IRQ = 9'h09C;

  // wide byte addresses
  localparam logic [11:0] WA_DMA = 12'h280;
  localparam logic [11:0] WA_IEN = 12'h284;
  localparam logic [11:0] WA_IRQ = 12'h288;
  localparam logic [11:0] WA_LOW = 12'h200;

  typedef struct packed {
    logic       col;
    logic       modu;
    logic       len;
    logic       per;
    logic       vol;
    logic       dma;
    logic       ien;
    logic       irq;
    logic [4:0] col_idx;
    logic [1:0] mod_idx;
    logic [1:0] ch;
  } leg_ev_t;

  function automatic logic [31:0] rgb12_to_24(input logic [15:0] d);
    return {8'h00, d[11:8], d[11:8], d[7:4], d[7:4], d[3:0], d[3:0]};
  endfunction

  function automatic logic [7:0] vol7_to_8(input logic [6:0] v);
    if (v[6]) return 8'hFF;
    return {v[5:0], 2'b00};
  endfunction

  function automatic logic [31:0] sext16(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  function automatic logic [31:0] len_x2(input logic [15:0] d);
    return {15'd0, d, 1'b0};
  endfunction

  function automatic logic [31:0] apply_sc(input logic [31:0] r,
                                           input logic [LEG_CH-1:0] m,
                                           input logic set);
    logic [31:0] mm;
    mm = 32'(m);
    return set ? (r | mm) : (r & ~mm);
  endfunction
endpackage

// File: rtl/xlat_legacy_dec.sv
module xlat_legacy_dec
  import xlat_pkg::*;
(
  input  logic          leg_we,
  input  logic [8:0]    leg_addr,
  output leg_ev_t       ev
);
  logic [8:0] aud_off;
  assign aud_off = leg_addr - LA_AUD;

  always_comb begin
    ev = '0;
    if (leg_we && !leg_addr[0]) begin
      if (leg_addr[8:6] == 3'b110) begin
        ev.col     = 1'b1;
        ev.col_idx = leg_addr[5:1];
      end
      if (leg_addr[8:3] == 6'b001100) begin
        ev.modu    = 1'b1;
        ev.mod_idx = leg_addr[2:1];
      end
      if (leg_addr >= LA_AUD && leg_addr < (LA_AUD + 9'h040)) begin
        ev.ch = aud_off[5:4];
        case (aud_off[3:0])
          4'h4:    ev.len = 1'b1;
          4'h6:    ev.per = 1'b1;
          4'h8:    ev.vol = 1'b1;
          default: ;
        endcase
      end
      ev.dma = (leg_addr == LA_DMA);
      ev.ien = (leg_addr == LA_IEN);
      ev.irq = (leg_addr == LA_IRQ);
    end
  end
endmodule

// File: rtl/xlat_palette.sv
module xlat_palette #(
  parameter int ENTRIES = 256,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          leg_ev,
  input  logic [IW-1:0] leg_idx,
  input  logic [31:0]   leg_rgb,
  input  logic          wa_ev,
  input  logic          wb_ev,
  input  logic [IW-1:0] w_idx,
  input  logic [31:0]   w_data,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_a,
  output logic [31:0]   rd_b
);
  logic [31:0] pal_a [ENTRIES];
  logic [31:0] pal_b [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        pal_a[i] <= '0;
        pal_b[i] <= '0;
      end
    end else begin
      if (wa_ev) pal_a[w_idx] <= w_data;
      if (wb_ev) pal_b[w_idx] <= w_data;
      if (leg_ev) begin          // later assignment: legacy wins (R11)
        pal_a[leg_idx] <= leg_rgb;
        pal_b[leg_idx] <= leg_rgb;
      end
    end
  end

  assign rd_a = pal_a[rd_idx];
  assign rd_b = pal_b[rd_idx];

  a_r2_both_palettes: assert property (@(posedge clk) disable iff (!rst_n)
    leg_ev |=> (pal_a[$past(leg_idx)] == pal_b[$past(leg_idx)]));
  a_r1_colour_stored: assert property (@(posedge clk) disable iff (!rst_n)
    leg_ev |=> (pal_a[$past(leg_idx)] == $past(leg_rgb)));
endmodule

// File: rtl/xlat_audio.sv
module xlat_audio
  import xlat_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  leg_ev_t       ev,
  input  logic [15:0]   leg_data,
  input  logic [CW-1:0] w_ch,
  input  logic          w_samp_ev,
  input  logic          w_per_ev,
  input  logic          w_vol_ev,
  input  logic          w_dma_ev,
  input  logic          w_ien_ev,
  input  logic          w_irq_ev,
  input  logic [31:0]   w_data,
  input  logic [CW-1:0] rd_ch,
  output logic [31:0]   rd_samp,
  output logic [31:0]   rd_per,
  output logic [31:0]   rd_vol,
  output logic [31:0]   dma_r,
  output logic [31:0]   ien_r,
  output logic [31:0]   irq_r
);
  logic [31:0] samp_r [NCH];
  logic [31:0] per_r  [NCH];
  logic [31:0] vol_r  [NCH];

  // named translation results for assertions
  logic [CW-1:0]     lch;
  logic [7:0]        vol8;
  logic              to_left;
  logic [31:0]       vol_img;
  logic [LEG_CH-1:0] dma_bits, int_bits;

  assign lch      = CW'(ev.ch);
  assign vol8     = vol7_to_8(leg_data[6:0]);
  assign to_left  = (ev.ch == 2'd0) || (ev.ch == 2'd3);
  assign vol_img  = to_left ? {24'd0, vol8} : {16'd0, vol8, 8'd0};
  assign dma_bits = leg_data[LEG_CH-1:0];
  assign int_bits = leg_data[7 +: LEG_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        samp_r[i] <= '0;
        per_r[i]  <= '0;
        vol_r[i]  <= '0;
      end
      dma_r <= '0;
      ien_r <= '0;
      irq_r <= '0;
    end else begin
      if (w_samp_ev) samp_r[w_ch] <= w_data;
      if (w_per_ev)  per_r[w_ch]  <= w_data;
      if (w_vol_ev)  vol_r[w_ch]  <= w_data;
      if (w_dma_ev)  dma_r <= w_data;
      if (w_ien_ev)  ien_r <= w_data;
      if (w_irq_ev)  irq_r <= w_data;
      if (ev.len) samp_r[lch] <= len_x2(leg_data);
      if (ev.per) per_r[lch]  <= {leg_data, 16'd0};
      if (ev.vol) vol_r[lch]  <= vol_img;
      if (ev.dma) dma_r <= apply_sc(w_dma_ev ? w_data : dma_r, dma_bits, leg_data[15]);
      if (ev.ien) ien_r <= apply_sc(w_ien_ev ? w_data : ien_r, int_bits, leg_data[15]);
      if (ev.irq) irq_r <= apply_sc(w_irq_ev ? w_data : irq_r, int_bits, leg_data[15]);
    end
  end

  assign rd_samp = samp_r[rd_ch];
  assign rd_per  = per_r[rd_ch];
  assign rd_vol  = vol_r[rd_ch];

  a_r4_len_even: assert property (@(posedge clk) disable iff (!rst_n)
    ev.len |=> (samp_r[$past(lch)][0] == 1'b0 && samp_r[$past(lch)][31:17] == '0));
  a_r5_ctl_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev.per |=> (per_r[$past(lch)][15:0] == 16'd0));
  a_r6_rear_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev.vol |=> (vol_r[$past(lch)][31:16] == 16'd0));
  a_r6_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    ev.vol |=> (vol_r[$past(lch)][7:0] == 8'd0 || vol_r[$past(lch)][15:8] == 8'd0));
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.dma && !w_dma_ev) |=> (dma_r[31:LEG_CH] == $past(dma_r[31:LEG_CH])));
  a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ien && !w_ien_ev) |=> (ien_r[31:LEG_CH] == $past(ien_r[31:LEG_CH])));
endmodule

// File: rtl/compat_xlat.sv
module compat_xlat
  import xlat_pkg::*;
#(
  parameter int NCH     = 32,
  parameter int ENTRIES = 256,
  parameter int NMOD    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        leg_we,
  input  logic [8:0]  leg_addr,
  input  logic [15:0] leg_data,
  input  logic        w_we,
  input  logic [11:0] w_addr,
  input  logic [31:0] w_data,
  input  logic [11:0] rd_addr,
  output logic [31:0] rd_data,
  output logic [31:0] aud_dma_en,
  output logic [31:0] aud_int_en,
  output logic [31:0] aud_int_req
);
  localparam int CW = $clog2(NCH);
  localparam int IW = $clog2(ENTRIES);
  localparam int MW = $clog2(NMOD);

  leg_ev_t ev;
  xlat_legacy_dec u_dec (.leg_we(leg_we), .leg_addr(leg_addr), .ev(ev));

  // wide-port decode
  logic w_ok, w_aud, w_mod, w_pa, w_pb;
  assign w_ok  = w_we && (w_addr[1:0] == 2'b00) && (w_addr >= WA_LOW);
  assign w_aud = w_ok && (w_addr[11:9] == 3'b011);
  assign w_mod = w_ok && (w_addr[11:4] == 8'h24);
  assign w_pa  = w_ok && (w_addr[11:10] == 2'b10);
  assign w_pb  = w_ok && (w_addr[11:10] == 2'b11);

  // modulo images
  logic [31:0] mod_r [NMOD];
  logic [MW-1:0] lmod_idx, wmod_idx;
  assign lmod_idx = MW'(ev.mod_idx);
  assign wmod_idx = MW'(w_addr[3:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NMOD; i++) mod_r[i] <= '0;
    end else begin
      if (w_mod)   mod_r[wmod_idx] <= w_data;
      if (ev.modu) mod_r[lmod_idx] <= sext16(leg_data);
    end
  end

  logic [31:0] pal_rd_a, pal_rd_b;
  xlat_palette #(.ENTRIES(ENTRIES)) u_pal (
    .clk(clk), .rst_n(rst_n),
    .leg_ev(ev.col), .leg_idx(IW'(ev.col_idx)), .leg_rgb(rgb12_to_24(leg_data)),
    .wa_ev(w_pa), .wb_ev(w_pb), .w_idx(IW'(w_addr[9:2])), .w_data(w_data),
    .rd_idx(IW'(rd_addr[9:2])), .rd_a(pal_rd_a), .rd_b(pal_rd_b)
  );

  logic [31:0] aud_samp, aud_per, aud_vol;
  xlat_audio #(.NCH(NCH)) u_aud (
    .clk(clk), .rst_n(rst_n), .ev(ev), .leg_data(leg_data),
    .w_ch(CW'(w_addr[8:4])),
    .w_samp_ev(w_aud && w_addr[3:2] == 2'd1),
    .w_per_ev (w_aud && w_addr[3:2] == 2'd2),
    .w_vol_ev (w_aud && w_addr[3:2] == 2'd3),
    .w_dma_ev (w_ok && w_addr == WA_DMA),
    .w_ien_ev (w_ok && w_addr == WA_IEN),
    .w_irq_ev (w_ok && w_addr == WA_IRQ),
    .w_data(w_data), .rd_ch(CW'(rd_addr[8:4])),
    .rd_samp(aud_samp), .rd_per(aud_per), .rd_vol(aud_vol),
    .dma_r(aud_dma_en), .ien_r(aud_int_en), .irq_r(aud_int_req)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr[1:0] == 2'b00) begin
      if (rd_addr[11:4] == 8'h24 && int'(rd_addr[3:2]) < NMOD)
        rd_data = mod_r[MW'(rd_addr[3:2])];
      else if (rd_addr == WA_DMA) rd_data = aud_dma_en;
      else if (rd_addr == WA_IEN) rd_data = aud_int_en;
      else if (rd_addr == WA_IRQ) rd_data = aud_int_req;
      else if (rd_addr[11:9] == 3'b011) begin
        case (rd_addr[3:2])
          2'd1:    rd_data = aud_samp;
          2'd2:    rd_data = aud_per;
          2'd3:    rd_data = aud_vol;
          default: rd_data = '0;
        endcase
      end
      else if (rd_addr[11:10] == 2'b10) rd_data = pal_rd_a;
      else if (rd_addr[11:10] == 2'b11) rd_data = pal_rd_b;
    end
  end

  a_r3_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ev.modu |=> (mod_r[$past(lmod_idx)][31:16] == {16{$past(leg_data[15])}}));
  a_r10_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (w_we && w_addr < WA_LOW && !ev.dma) |=> $stable(aud_dma_en));
endmodule

// File: tb/compat_xlat_bench.sv
module compat_xlat_bench;
  logic        clk = 0, rst_n = 0;
  logic        leg_we = 0, w_we = 0;
  logic [8:0]  leg_addr = 0;
  logic [15:0] leg_data = 0;
  logic [11:0] w_addr = 0, rd_addr = 0;
  logic [31:0] w_data = 0;
  logic [31:0] rd_data, aud_dma_en, aud_int_en, aud_int_req;

  compat_xlat u_compat_xlat (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_pa [256], m_pb [256], m_mod [4];
  logic [31:0] m_samp [32], m_per [32], m_vol [32];
  logic [31:0] m_dma, m_ien, m_irq;

  function automatic logic [31:0] b_colour(input logic [15:0] d);
    logic [31:0] r;
    r = 32'(d[11:8]) * 17 * 65536 + 32'(d[7:4]) * 17 * 256 + 32'(d[3:0]) * 17;
    return r;
  endfunction

  function automatic logic [7:0] b_level(input logic [15:0] d);
    int v;
    if (d[6]) return 8'd255;
    v = int'(d[5:0]) * 4;
    if (v > 255) v = 255;
    return 8'(v);
  endfunction

  function automatic logic [31:0] exp_at(input logic [11:0] a);
    if (a[1:0] != 0 || a < 12'h200) return 0;
    if (a >= 12'h240 && a < 12'h250) return m_mod[(a - 12'h240) / 4];
    if (a == 12'h280) return m_dma;
    if (a == 12'h284) return m_ien;
    if (a == 12'h288) return m_irq;
    if (a >= 12'h600 && a < 12'h800) begin
      case ((a % 16) / 4)
        1: return m_samp[(a - 12'h600) / 16];
        2: return m_per[(a - 12'h600) / 16];
        3: return m_vol[(a - 12'h600) / 16];
        default: return 0;
      endcase
    end
    if (a >= 12'h800 && a < 12'hC00) return m_pa[(a - 12'h800) / 4];
    if (a >= 12'hC00) return m_pb[(a - 12'hC00) / 4];
    return 0;
  endfunction

  // model update for a legacy write
  task automatic model_leg(input logic [8:0] a, input logic [15:0] d);
    int c;
    logic [31:0] msk;
    if (a >= 9'h180 && a < 9'h1C0) begin
      m_pa[(a - 9'h180) / 2] = b_colour(d);
      m_pb[(a - 9'h180) / 2] = b_colour(d);
    end else if (a >= 9'h060 && a < 9'h068)
      m_mod[(a - 9'h060) / 2] = (d[15] ? 32'hFFFF0000 : 0) | 32'(d);
    else if (a >= 9'h0A0 && a < 9'h0E0) begin
      c = (a - 9'h0A0) / 16;
      case ((a - 9'h0A0) % 16)
        4: m_samp[c] = 32'(d) * 2;
        6: m_per[c] = 32'(d) << 16;
        8: m_vol[c] = (c == 0 || c == 3) ? 32'(b_level(d)) : 32'(b_level(d)) << 8;
        default: ;
      endcase
    end else if (a == 9'h096) begin
      msk = 32'(d[3:0]);
      m_dma = d[15] ? (m_dma | msk) : (m_dma & ~msk);
    end else if (a == 9'h09A || a == 9'h09C) begin
      msk = 32'((d >> 7) & 16'hF);
      if (a == 9'h09A) m_ien = d[15] ? (m_ien | msk) : (m_ien & ~msk);
      else             m_irq = d[15] ? (m_irq | msk) : (m_irq & ~msk);
    end
  endtask

  task automatic model_wide(input logic [11:0] a, input logic [31:0] d);
    if (a[1:0] != 0 || a < 12'h200) return;
    if (a >= 12'h240 && a < 12'h250) m_mod[(a - 12'h240) / 4] = d;
    else if (a == 12'h280) m_dma = d;
    else if (a == 12'h284) m_ien = d;
    else if (a == 12'h288) m_irq = d;
    else if (a >= 12'h600 && a < 12'h800) begin
      case ((a % 16) / 4)
        1: m_samp[(a - 12'h600) / 16] = d;
        2: m_per[(a - 12'h600) / 16] = d;
        3: m_vol[(a - 12'h600) / 16] = d;
        default: ;
      endcase
    end
    else if (a >= 12'h800 && a < 12'hC00) m_pa[(a - 12'h800) / 4] = d;
    else if (a >= 12'hC00) m_pb[(a - 12'hC00) / 4] = d;
  endtask

  task automatic leg_wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk); leg_we = 1; leg_addr = a; leg_data = d;
    @(negedge clk); leg_we = 0;
    model_leg(a, d);
  endtask

  task automatic wide_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); w_we = 1; w_addr = a; w_data = d;
    @(negedge clk); w_we = 0;
    model_wide(a, d);
  endtask

  task automatic both_wr(input logic [8:0] la, input logic [15:0] ld,
                         input logic [11:0] wa, input logic [31:0] wd);
    @(negedge clk);
    leg_we = 1; leg_addr = la; leg_data = ld;
    w_we = 1; w_addr = wa; w_data = wd;
    @(negedge clk); leg_we = 0; w_we = 0;
    model_wide(wa, wd);
    model_leg(la, ld);
  endtask

  task automatic chk(input string req, input logic [11:0] a, input logic [31:0] e);
    rd_addr = a; #1;
    n_chk++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd_data, e);
    end
  endtask

  task automatic chk_val(input string req, input logic [31:0] act, input logic [31:0] e);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, e);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_pa[i] = 0; m_pb[i] = 0; end
    for (int i = 0; i < 32; i++) begin m_samp[i] = 0; m_per[i] = 0; m_vol[i] = 0; end
    for (int i = 0; i < 4; i++) m_mod[i] = 0;
    m_dma = 0; m_ien = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12 reset state
    chk("R12", 12'h800, 0); chk("R12", 12'hFFC, 0); chk("R12", 12'h240, 0);
    chk("R12", 12'h604, 0); chk_val("R12", aud_dma_en | aud_int_en | aud_int_req, 0);

    // R1 / R2 colour
    leg_wr(9'h180, 16'h0FA5);
    chk("R1", 12'h800, 32'h00FFAA55);
    chk("R2", 12'hC00, 32'h00FFAA55);
    chk("R2", 12'h804, 0);
    leg_wr(9'h1BE, 16'hF0F0);
    chk("R1", 12'h87C, 32'h0000FF00);
    chk("R2", 12'hC7C, 32'h0000FF00);

    // R3 modulo
    leg_wr(9'h062, 16'hFFFE);
    chk("R3", 12'h244, 32'hFFFFFFFE);
    leg_wr(9'h066, 16'h7FFF);
    chk("R3", 12'h24C, 32'h00007FFF);

    // R4 length, R5 period
    wide_wr(12'h624, 32'hFFFFFFFF);
    leg_wr(9'h0B4, 16'h8001);
    chk("R4", 12'h614, 32'h00010002);
    wide_wr(12'h628, 32'h0000FFFF);
    leg_wr(9'h0B6, 16'h1234);
    chk("R5", 12'h618, 32'h12340000);

    // R6 volume, all legacy channels
    wide_wr(12'h60C, 32'hFFFFFFFF);
    leg_wr(9'h0A8, 16'h0040);
    chk("R6", 12'h60C, 32'h000000FF);
    leg_wr(9'h0B8, 16'h0040);
    chk("R6", 12'h61C, 32'h0000FF00);
    leg_wr(9'h0C8, 16'h003F);
    chk("R6", 12'h62C, 32'h0000FC00);
    leg_wr(9'h0D8, 16'h0010);
    chk("R6", 12'h63C, 32'h00000040);
    leg_wr(9'h0D8, 16'h007F);
    chk("R6", 12'h63C, 32'h000000FF);

    // R7 / R8 set/clear
    wide_wr(12'h280, 32'hA5A5A5A0);
    leg_wr(9'h096, 16'h8005);
    chk_val("R7", aud_dma_en, 32'hA5A5A5A5);
    leg_wr(9'h096, 16'h0004);
    chk("R7", 12'h280, 32'hA5A5A5A1);
    wide_wr(12'h284, 32'hFFFF0000);
    leg_wr(9'h09A, 16'h8000 | (16'hA << 7));
    chk_val("R8", aud_int_en, 32'hFFFF000A);
    leg_wr(9'h09C, 16'h8000 | (16'hF << 7));
    leg_wr(9'h09C, 16'h0000 | (16'h3 << 7));
    chk_val("R8", aud_int_req, 32'h0000000C);

    // R9 aligned / misaligned
    wide_wr(12'h900, 32'hDEADBEEF);
    chk("R9", 12'h900, 32'hDEADBEEF);
    wide_wr(12'h802, 32'h11111111);
    chk("R9", 12'h800, 32'h00FFAA55);
    wide_wr(12'h7F4, 32'h01234567);
    chk("R9", 12'h7F4, 32'h01234567);

    // R10 low region ignored
    wide_wr(12'h180, 32'h12345678);
    chk("R10", 12'h180, 0);
    chk("R10", 12'h800, 32'h00FFAA55);
    wide_wr(12'h096, 32'hFFFFFFFF);
    chk_val("R10", aud_dma_en, 32'hA5A5A5A1);

    // R11 collisions
    both_wr(9'h18A, 16'h0123, 12'h814, 32'hCAFEF00D);
    chk("R11", 12'h814, 32'h00112233);
    chk("R11", 12'hC14, 32'h00112233);
    both_wr(9'h060, 16'h8000, 12'h240, 32'h00000055);
    chk("R11", 12'h240, 32'hFFFF8000);

    // constrained random phase
    void'($urandom(32'h5EED));
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [8:0] la;
      logic [11:0] wa;
      logic [15:0] d16;
      logic [31:0] d32;
      op = $urandom_range(0, 7);
      d16 = 16'($urandom);
      d32 = $urandom;
      case (op)
        0: begin la = 9'h180 + 9'($urandom_range(0, 31) * 2); leg_wr(la, d16);
             chk("R2", 12'h800 + 12'((la - 9'h180) * 2), exp_at(12'h800 + 12'((la - 9'h180) * 2)));
             chk("R1", 12'hC00 + 12'((la - 9'h180) * 2), exp_at(12'hC00 + 12'((la - 9'h180) * 2))); end
        1: begin la = 9'h060 + 9'($urandom_range(0, 3) * 2); leg_wr(la, d16);
             chk("R3", 12'h240 + 12'((la - 9'h060) * 2), exp_at(12'h240 + 12'((la - 9'h060) * 2))); end
        2: begin int c; c = $urandom_range(0, 3); leg_wr(9'h0A4 + 9'(c * 16), d16);
             chk("R4", 12'h604 + 12'(c * 16), exp_at(12'h604 + 12'(c * 16))); end
        3: begin int c; c = $urandom_range(0, 3); leg_wr(9'h0A6 + 9'(c * 16), d16);
             chk("R5", 12'h608 + 12'(c * 16), exp_at(12'h608 + 12'(c * 16))); end
        4: begin int c; c = $urandom_range(0, 3);
             d16[5:0] = ($urandom_range(0, 3) == 0) ? 6'd63 : d16[5:0];
             leg_wr(9'h0A8 + 9'(c * 16), d16);
             chk("R6", 12'h60C + 12'(c * 16), exp_at(12'h60C + 12'(c * 16))); end
        5: begin leg_wr(9'h096, d16); chk_val("R7", aud_dma_en, m_dma); end
        6: begin la = ($urandom_range(0, 1) == 0) ? 9'h09A : 9'h09C; leg_wr(la, d16);
             chk_val("R8", aud_int_en, m_ien); chk_val("R8", aud_int_req, m_irq); end
        default: begin wa = 12'($urandom); wide_wr(wa, d32);
             chk("R9", {wa[11:2], 2'b00}, exp_at({wa[11:2], 2'b00})); end
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule